// File: doc/BRIEF.md
# Colour Lookup Table Host Access Port

This block sits between a microprocessor bus and a colour lookup table of 2**IDX_W entries, each holding a red, a green and a blue component. The host sees a few directly addressed byte registers. One sets the write pointer and one sets the read pointer. A shared data register carries colour components one byte at a time. A complete entry is always moved as three bytes in the order red, green, blue. After the third byte the pointer steps to the next entry, so the host can stream a run of entries without setting the address again.

A separate lookup port serves the pixel pipeline. It reads the table on every clock, whatever the host is doing, so the display keeps running while software updates or inspects the table. A mode input chooses 8-bit or 6-bit colour components.

Top module: `pal_host_port`

## Requirements
- R1: After synchronous reset, the write pointer and read pointer are 0, both byte sequencers are at the red phase, and host_rdata and pix_rgb are 0.
- R2: A host write to register 4'h0 loads the write pointer from host_wdata and returns the write sequencer to red. A host read of 4'h0 returns the write pointer.
- R3: Host writes to register 4'h1 are taken as red, green and blue in turn. The table entry {red,green,blue} is written in a single step when blue is accepted, and the write pointer then advances by one.
- R4: A host write to register 4'h3 loads the read pointer and returns the read sequencer to red. A host read of 4'h3 returns the read pointer.
- R5: Host reads of register 4'h1 return red, green and blue of the entry at the read pointer, in that order. After blue the read pointer advances by one. host_rdata is updated on the edge that accepts the read. A read of 4'h1 must come at least one idle cycle after the previous host access.
- R6: When mode8 is 0, a written component is stored with its top two bits cleared, and a component read from 4'h1 returns only its low COMP_W-2 bits with the top two bits 0.
- R7: Both pointers wrap from the last entry to 0 when they advance.
- R8: pix_rgb shows the stored entry {red,green,blue} at pix_idx one clock after pix_idx is presented. The value is not masked by mode8.
- R9: If the host commits an entry in the same cycle that the pixel port addresses it, pix_rgb shows the old contents on the next clock and the new contents one clock later.
- R10: Red and green bytes are held aside until blue arrives. Reloading the write pointer drops them, leaves the entry unchanged, and makes the next data byte red.
- R11: The read and write byte sequencers are independent: host writes do not change the read phase, and host reads do not change the write phase.
- R12: Writes to register addresses other than 4'h0, 4'h1 and 4'h3 have no effect, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode8 | input | 1 | 1 selects 8-bit components, 0 selects 6-bit |
| host_cs | input | 1 | Host access strobe, one cycle |
| host_wr | input | 1 | Access is a write |
| host_rd | input | 1 | Access is a read |
| host_addr | input | 4 | Register select |
| host_wdata | input | COMP_W | Host write data |
| host_rdata | output | COMP_W | Registered host read data |
| pix_idx | input | IDX_W | Pixel lookup index |
| pix_rgb | output | 3*COMP_W | Registered pixel colour {red,green,blue} |

## Verification
The bench aims at the sequencing corners. A red or green byte cut short by a pointer reload would leave a torn entry, or shift the next triple by one byte. Read and write phases that share a counter would return green when red is expected after an interleaved write. A pointer that does not wrap would put the next triple beyond the table. The bench also drives a host commit and a pixel lookup on the same entry in the same cycle, where a write-first memory would show the new colour one frame slot early. It also checks the 6-bit mode on both the store and the read path, where a design that masks only one side would leak the top bits.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Byte phase of an RGB triple on the host data register
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } rgb_phase_e;

  localparam int unsigned REG_AW = 4;
  localparam logic [REG_AW-1:0] REG_WPTR = 4'h0;
  localparam logic [REG_AW-1:0] REG_DATA = 4'h1;
  localparam logic [REG_AW-1:0] REG_RPTR = 4'h3;
endpackage

// File: rtl/pal_wr_seq.sv
module pal_wr_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode8,
  input  logic                  load_ptr,
  input  logic                  data_wr,
  input  logic [COMP_W-1:0]     wdata,
  output logic [IDX_W-1:0]      wr_ptr,
  output logic                  commit,
  output logic [3*COMP_W-1:0]   entry
);
  localparam int unsigned LOW_W = COMP_W - 2;
  localparam logic [COMP_W-1:0] NARROW = {2'b00, {LOW_W{1'b1}}};

  rgb_phase_e        phase;
  logic [COMP_W-1:0] stage_r, stage_g, comp;

  assign comp   = mode8 ? wdata : (wdata & NARROW);
  assign commit = data_wr && !load_ptr && (phase == PH_BLU);
  assign entry  = {stage_r, stage_g, comp};

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      phase   <= PH_RED;
      stage_r <= '0;
      stage_g <= '0;
    end else if (load_ptr) begin
      wr_ptr <= wdata[IDX_W-1:0];
      phase  <= PH_RED;
    end else if (data_wr) begin
      case (phase)
        PH_RED: begin
          stage_r <= comp;
          phase   <= PH_GRN;
        end
        PH_GRN: begin
          stage_g <= comp;
          phase   <= PH_BLU;
        end
        PH_BLU: begin
          wr_ptr <= wr_ptr + 1'b1;
          phase  <= PH_RED;
        end
        default: phase <= PH_RED;
      endcase
    end
  end
endmodule

// File: rtl/pal_rd_seq.sv
module pal_rd_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode8,
  input  logic                  load_ptr,
  input  logic                  data_rd,
  input  logic [COMP_W-1:0]     wdata,
  input  logic [3*COMP_W-1:0]   ram_q,
  output logic [IDX_W-1:0]      rd_ptr,
  output logic [COMP_W-1:0]     comp_out
);
  localparam int unsigned LOW_W = COMP_W - 2;
  localparam logic [COMP_W-1:0] NARROW = {2'b00, {LOW_W{1'b1}}};

  rgb_phase_e        phase;
  logic [COMP_W-1:0] sel;

  always_comb begin
    case (phase)
      PH_RED:  sel = ram_q[3*COMP_W-1:2*COMP_W];
      PH_GRN:  sel = ram_q[2*COMP_W-1:COMP_W];
      default: sel = ram_q[COMP_W-1:0];
    endcase
    comp_out = mode8 ? sel : (sel & NARROW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      phase  <= PH_RED;
    end else if (load_ptr) begin
      rd_ptr <= wdata[IDX_W-1:0];
      phase  <= PH_RED;
    end else if (data_rd) begin
      case (phase)
        PH_RED: phase <= PH_GRN;
        PH_GRN: phase <= PH_BLU;
        PH_BLU: begin
          rd_ptr <= rd_ptr + 1'b1;
          phase  <= PH_RED;
        end
        default: phase <= PH_RED;
      endcase
    end
  end
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IDX_W-1:0]      waddr,
  input  logic [3*COMP_W-1:0]   wentry,
  input  logic [IDX_W-1:0]      host_raddr,
  output logic [3*COMP_W-1:0]   host_q,
  input  logic [IDX_W-1:0]      pix_raddr,
  output logic [3*COMP_W-1:0]   pix_q
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned EW    = 3 * COMP_W;

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  // Two read ports, read-before-write against the host write
  logic [IDX_W-1:0] raddr [2];
  logic [EW-1:0]    rq    [2];
  assign raddr[0] = host_raddr;
  assign raddr[1] = pix_raddr;
  assign host_q   = rq[0];
  assign pix_q    = rq[1];

  for (genvar p = 0; p < 2; p++) begin : g_rport
    always_ff @(posedge clk) begin
      if (rst) rq[p] <= '0;
      else     rq[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/pal_host_port.sv
module pal_host_port
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode8,
  input  logic                  host_cs,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [REG_AW-1:0]     host_addr,
  input  logic [COMP_W-1:0]     host_wdata,
  output logic [COMP_W-1:0]     host_rdata,
  input  logic [IDX_W-1:0]      pix_idx,
  output logic [3*COMP_W-1:0]   pix_rgb
);
  logic wr_acc, rd_acc;
  logic ld_wptr, ld_rptr, data_wr, data_rd;
  logic [IDX_W-1:0]    wr_ptr, rd_ptr;
  logic                ram_we;
  logic [3*COMP_W-1:0] wentry, host_q;
  logic [COMP_W-1:0]   rd_comp, wptr_ext, rptr_ext;

  assign wr_acc  = host_cs && host_wr;
  assign rd_acc  = host_cs && host_rd && !host_wr;
  assign ld_wptr = wr_acc && (host_addr == REG_WPTR);
  assign ld_rptr = wr_acc && (host_addr == REG_RPTR);
  assign data_wr = wr_acc && (host_addr == REG_DATA);
  assign data_rd = rd_acc && (host_addr == REG_DATA);

  pal_wr_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_wr (
    .clk(clk), .rst(rst), .mode8(mode8),
    .load_ptr(ld_wptr), .data_wr(data_wr), .wdata(host_wdata),
    .wr_ptr(wr_ptr), .commit(ram_we), .entry(wentry)
  );

  pal_rd_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_rd (
    .clk(clk), .rst(rst), .mode8(mode8),
    .load_ptr(ld_rptr), .data_rd(data_rd), .wdata(host_wdata),
    .ram_q(host_q), .rd_ptr(rd_ptr), .comp_out(rd_comp)
  );

  pal_ram #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_ram (
    .clk(clk), .rst(rst),
    .we(ram_we), .waddr(wr_ptr), .wentry(wentry),
    .host_raddr(rd_ptr), .host_q(host_q),
    .pix_raddr(pix_idx), .pix_q(pix_rgb)
  );

  always_comb begin
    wptr_ext = '0;
    rptr_ext = '0;
    wptr_ext[IDX_W-1:0] = wr_ptr;
    rptr_ext[IDX_W-1:0] = rd_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (rd_acc) begin
      case (host_addr)
        REG_WPTR: host_rdata <= wptr_ext;
        REG_RPTR: host_rdata <= rptr_ext;
        REG_DATA: host_rdata <= rd_comp;
        default:  host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pal_host_port_chk.sv
module pal_host_port_chk
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               mode8,
  input logic               host_cs,
  input logic               host_wr,
  input logic               host_rd,
  input logic [REG_AW-1:0]  host_addr,
  input logic [COMP_W-1:0]  host_wdata,
  input logic [COMP_W-1:0]  host_rdata,
  input logic [IDX_W-1:0]   wr_ptr,
  input logic [IDX_W-1:0]   rd_ptr,
  input logic               ram_we
);
  a_r2_wptr_load: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_wr && host_addr == REG_WPTR)
      |=> wr_ptr == $past(host_wdata[IDX_W-1:0]));

  a_r4_rptr_load: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_wr && host_addr == REG_RPTR)
      |=> rd_ptr == $past(host_wdata[IDX_W-1:0]));

  a_r3_commit_src: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (host_cs && host_wr && host_addr == REG_DATA));

  a_r7_wptr_step: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> wr_ptr == $past(wr_ptr) + 1'b1);

  a_r6_narrow_read: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_rd && !host_wr && host_addr == REG_DATA && !mode8)
      |=> host_rdata[COMP_W-1:COMP_W-2] == 2'b00);

  a_r11_rptr_hold: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_wr && host_addr != REG_RPTR) |=> $stable(rd_ptr));
endmodule

bind pal_host_port pal_host_port_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_chk (
  .clk(clk), .rst(rst), .mode8(mode8), .host_cs(host_cs), .host_wr(host_wr),
  .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ram_we(ram_we)
);

// File: tb/pal_host_port_bench.sv
module pal_host_port_bench;
  localparam int IDX_W  = 8;
  localparam int COMP_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode8 = 1'b1;
  logic host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [7:0] pix_idx = '0;
  logic [23:0] pix_rgb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pal_host_port #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_pal_host_port (
    .clk(clk), .rst(rst), .mode8(mode8),
    .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles exp < 50000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic hwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_cs = 1'b0; host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic put_entry(input logic [7:0] idx, input logic [23:0] v);
    hwr(4'h0, idx);
    hwr(4'h1, v[23:16]);
    hwr(4'h1, v[15:8]);
    hwr(4'h1, v[7:0]);
  endtask

  task automatic get_entry(input logic [7:0] idx, output logic [23:0] v);
    logic [7:0] r, g, b;
    hwr(4'h3, idx);
    hrd(4'h1, r);
    hrd(4'h1, g);
    hrd(4'h1, b);
    v = {r, g, b};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 host_rdata", host_rdata, 8'h00);
    chk("R1 pix_rgb", pix_rgb, 24'h0);
    hrd(4'h0, d); chk("R1 wptr", d, 8'h00);
    hrd(4'h3, d); chk("R1 rptr", d, 8'h00);
  endtask

  task automatic t_stream;
    logic [23:0] v;
    logic [7:0] d;
    hwr(4'h0, 8'h05);
    hrd(4'h0, d); chk("R2 wptr load", d, 8'h05);
    hwr(4'h1, 8'h12); hwr(4'h1, 8'h34); hwr(4'h1, 8'h56);
    hwr(4'h1, 8'h9A); hwr(4'h1, 8'hBC); hwr(4'h1, 8'hDE);
    hrd(4'h0, d); chk("R3 wptr after two triples", d, 8'h07);
    hwr(4'h3, 8'h05);
    hrd(4'h3, d); chk("R4 rptr load", d, 8'h05);
    get_entry(8'h05, v); chk("R3 R5 entry 5", v, 24'h123456);
    hrd(4'h3, d); chk("R5 rptr advanced", d, 8'h06);
    hrd(4'h1, d); chk("R5 next red", d, 8'h9A);
    hrd(4'h1, d); chk("R5 next green", d, 8'hBC);
    hrd(4'h1, d); chk("R5 next blue", d, 8'hDE);
  endtask

  task automatic t_narrow;
    logic [23:0] v;
    mode8 = 1'b0;
    put_entry(8'h28, 24'hFFC381);
    get_entry(8'h28, v); chk("R6 narrow read", v, 24'h3F0301);
    mode8 = 1'b1;
    get_entry(8'h28, v); chk("R6 narrow store", v, 24'h3F0301);
    put_entry(8'h29, 24'hFF80C0);
    mode8 = 1'b0;
    get_entry(8'h29, v); chk("R6 narrow read of wide entry", v, 24'h3F0000);
    mode8 = 1'b1;
  endtask

  task automatic t_wrap;
    logic [23:0] v;
    logic [7:0] d;
    put_entry(8'h00, 24'h010203);
    put_entry(8'hFF, 24'hA1A2A3);
    hrd(4'h0, d); chk("R7 wptr wrap", d, 8'h00);
    get_entry(8'hFF, v); chk("R7 last entry", v, 24'hA1A2A3);
    hrd(4'h3, d); chk("R7 rptr wrap", d, 8'h00);
    hrd(4'h1, d); chk("R7 red after wrap", d, 8'h01);
  endtask

  task automatic t_pixel;
    put_entry(8'h40, 24'h445566);
    put_entry(8'h41, 24'h778899);
    mode8 = 1'b0;
    @(negedge clk); pix_idx = 8'h40;
    @(negedge clk); chk("R8 pixel entry 40", pix_rgb, 24'h445566);
    pix_idx = 8'h41;
    @(negedge clk); chk("R8 pixel entry 41 unmasked", pix_rgb, 24'h778899);
    mode8 = 1'b1;
  endtask

  task automatic t_collide;
    put_entry(8'h50, 24'h111111);
    hwr(4'h0, 8'h50);
    hwr(4'h1, 8'h22);
    hwr(4'h1, 8'h33);
    @(negedge clk);
    pix_idx = 8'h50;
    host_cs = 1'b1; host_wr = 1'b1; host_addr = 4'h1; host_wdata = 8'h44;
    @(negedge clk);
    host_cs = 1'b0; host_wr = 1'b0;
    chk("R9 old value on collision", pix_rgb, 24'h111111);
    @(negedge clk);
    chk("R9 new value next cycle", pix_rgb, 24'h223344);
  endtask

  task automatic t_partial;
    logic [23:0] v;
    put_entry(8'h0A, 24'hAABBCC);
    hwr(4'h0, 8'h0A);
    hwr(4'h1, 8'h11);
    hwr(4'h1, 8'h22);
    hwr(4'h0, 8'h0A);
    get_entry(8'h0A, v); chk("R10 entry untouched", v, 24'hAABBCC);
    hwr(4'h1, 8'h33); hwr(4'h1, 8'h44); hwr(4'h1, 8'h55);
    get_entry(8'h0A, v); chk("R10 phase restarts at red", v, 24'h334455);
  endtask

  task automatic t_interleave;
    logic [23:0] v;
    logic [7:0] r, g, b;
    put_entry(8'h14, 24'hC1C2C3);
    hwr(4'h3, 8'h14);
    hrd(4'h1, r);
    put_entry(8'h20, 24'hD1D2D3);
    hrd(4'h1, g);
    hrd(4'h1, b);
    chk("R11 read phase kept across writes", {r, g, b}, 24'hC1C2C3);
    hwr(4'h0, 8'h21);
    hwr(4'h1, 8'hE1);
    hwr(4'h3, 8'h14);
    hrd(4'h1, r);
    chk("R4 reload returns red", r, 8'hC1);
    hwr(4'h1, 8'hE2); hwr(4'h1, 8'hE3);
    get_entry(8'h21, v); chk("R11 write phase kept across reads", v, 24'hE1E2E3);
  endtask

  task automatic t_unused;
    logic [23:0] v;
    logic [7:0] d;
    hwr(4'h0, 8'h1E);
    hwr(4'h1, 8'h01);
    hwr(4'h2, 8'h77);
    hwr(4'hF, 8'h66);
    hwr(4'h1, 8'h02);
    hwr(4'h1, 8'h03);
    get_entry(8'h1E, v); chk("R12 unused writes ignored", v, 24'h010203);
    hrd(4'h0, d); chk("R12 wptr unchanged", d, 8'h1F);
    hrd(4'h2, d); chk("R12 unused read zero", d, 8'h00);
  endtask

  initial begin
    t_reset;
    t_stream;
    t_narrow;
    t_wrap;
    t_pixel;
    t_collide;
    t_partial;
    t_interleave;
    t_unused;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule